// File: doc/BRIEF.md
# Readout Deflection Mode Selector

This block decides which readout display mode a display controller is in, and steers digital deflection words to the horizontal and vertical outputs to match. Four source words are offered on every cycle: the horizontal DAC word, the vertical DAC word, a cursor-0 level and a delay-reference-1 level. In character mode the two DAC words pass straight through. In each of the four cursor modes one axis carries the horizontal DAC word and the other carries a fixed level. In the horizontal cursor modes the horizontal DAC word is sent to the vertical output.

The mode is chosen only at a rising edge of the dot-request strobe. The strobe is sampled in the block's clock domain. A high cursor-select bit at a strobe sets a cursor enable. While that enable is set, three dot-data bits pick the cursor mode. Once set, the enable stays set whatever the cursor-select bit does. The cursor-select bit is sampled again only at the first strobe after a return-to-character code.

Top module: `readout_mode_sel`

## Requirements
- R1: While `arst_n` is low, and until the synchronized reset is released, the block holds `mode_code` at 0 and both deflection outputs at 0, with the cursor enable cleared. The cleared enable is observed at the ports: the first strobe with `cur_sel` low after reset yields character mode.
- R2: Mode state changes only in the clock that samples a 0-to-1 transition of `dot_req`. Holding `dot_req` high over several clocks while `cur_sel` and `dot_data` change does not alter `mode_code`.
- R3: With the enable cleared, a strobe with `cur_sel` low selects character mode (code 0). Character mode drives `h_defl` from `hdac_word` and `v_defl` from `vdac_word`.
- R4: With the enable cleared, a strobe with `cur_sel` high sets the enable and decodes `dot_data` at that same strobe. The bit order is `dot_data[2]`=DD5, `dot_data[1]`=DD4, `dot_data[0]`=DD3.
- R5: While the enable is set, the DD5/DD4/DD3 decode is: 0,1,0 gives vertical cursor 1 (code 1); 0,1,1 gives horizontal cursor 1 (code 2); 1,0,0 gives vertical cursor 0 (code 3); 1,0,1 gives horizontal cursor 0 (code 4).
- R6: Once the enable is set, `cur_sel` has no effect on later strobes until a return code has been decoded. A strobe with `cur_sel` low still decodes `dot_data` as in R5.
- R7: The code DD5=0, DD4=0 (any DD3) is the return code. It selects code 0 at that strobe. At the next strobe `cur_sel` is sampled again: low clears the enable and keeps character mode; high keeps the enable and decodes `dot_data`.
- R8: With the enable set, the pattern DD5=1, DD4=1 (any DD3) leaves `mode_code` unchanged.
- R9: Cursor routing is as follows. Code 1 sends hdac to H and dref1 to V. Code 2 sends dref1 to H and hdac to V. Code 3 sends hdac to H and cur0 to V. Code 4 sends cur0 to H and hdac to V.
- R10: The deflection outputs are registered. A change of a source word appears on the outputs one clock later. A new mode reaches the outputs one clock after `mode_code` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_sel | input | 1 | Cursor-select bit |
| dot_data | input | 3 | Dot-data bits {DD5, DD4, DD3} |
| dot_req | input | 1 | Dot-request strobe, level sampled on `clk` |
| hdac_word | input | WORD_W | Horizontal DAC source word |
| vdac_word | input | WORD_W | Vertical DAC source word |
| cur0_word | input | WORD_W | Cursor-0 level word |
| dref1_word | input | WORD_W | Delay-reference-1 level word |
| h_defl | output | WORD_W | Registered horizontal deflection word |
| v_defl | output | WORD_W | Registered vertical deflection word |
| mode_code | output | 3 | Active mode: 0 character, 1..4 cursor modes per R5 |

## Verification
Several rules are checked by assertions on every cycle:
- the mode is frozen between strobe edges;
- the enable is sticky until a return code;
- a cursor code never appears without the enable;
- an undefined pattern holds the mode;
- the outputs match the selected sources one clock on.

Other behaviour needs the bench's scenarios. These cover the full enter, ignore, return and exit sequence across several strobes, and a strobe held high while its data changes. They also cover the one-clock output latency against randomly changing source words. Those scenarios are compared with an independent model of the mode rules.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [2:0] {
    MODE_CHAR = 3'd0,
    MODE_VC1  = 3'd1,
    MODE_HC1  = 3'd2,
    MODE_VC0  = 3'd3,
    MODE_HC0  = 3'd4
  } rdo_mode_e;

  // dd = {DD5, DD4, DD3}
  function automatic logic dd_is_return(input logic [2:0] dd);
    return (dd[2] == 1'b0) && (dd[1] == 1'b0);
  endfunction

  function automatic logic dd_is_undef(input logic [2:0] dd);
    return (dd[2] == 1'b1) && (dd[1] == 1'b1);
  endfunction

  function automatic rdo_mode_e dd_to_cursor(input logic [2:0] dd);
    rdo_mode_e m;
    case (dd)
      3'b010:  m = MODE_VC1;
      3'b011:  m = MODE_HC1;
      3'b100:  m = MODE_VC0;
      3'b101:  m = MODE_HC0;
      default: m = MODE_CHAR;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rdo_rst_sync.sv
module rdo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[LAST];

  initial begin
    assert (STAGES >= 1) else $error("rdo_rst_sync: STAGES must be at least 1");
  end

endmodule

// File: rtl/rdo_strobe_det.sv
module rdo_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = strobe_i;
    rise_o = strobe_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R2: no two detections in consecutive clocks
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/rdo_mode_ctl.sv
module rdo_mode_ctl
  import rdo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       csel_i,
  input  logic [2:0] dd_i,
  output rdo_mode_e  mode_o
);

  logic      en_q,   en_d;
  logic      ret_q,  ret_d;
  rdo_mode_e mode_q, mode_d;
  logic      en_in;
  logic      load;

  // enable input: forced high while a cursor run is live and not returned
  always_comb begin
    en_in = (en_q && !ret_q) ? 1'b1 : csel_i;
    load  = rise_i;
    en_d   = en_q;
    ret_d  = ret_q;
    mode_d = mode_q;
    if (load) begin
      en_d = en_in;
      if (!en_in) begin
        mode_d = MODE_CHAR;
        ret_d  = 1'b0;
      end else if (dd_is_return(dd_i)) begin
        mode_d = MODE_CHAR;
        ret_d  = 1'b1;
      end else if (dd_is_undef(dd_i)) begin
        ret_d  = 1'b0;
      end else begin
        mode_d = dd_to_cursor(dd_i);
        ret_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ret_q  <= 1'b0;
      mode_q <= MODE_CHAR;
    end else if (load) begin
      en_q   <= en_d;
      ret_q  <= ret_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(mode_q) && $stable(en_q));

  assert_enable_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !en_q && csel_i) |=> en_q);

  assert_cursor_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_CHAR) |-> en_q);

  assert_sticky_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !ret_q) |=> en_q);

  assert_exit_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && en_q && ret_q && !csel_i) |=> (!en_q && mode_q == MODE_CHAR));

  assert_undef_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && en_q && !ret_q && dd_i[2] && dd_i[1]) |=> $stable(mode_q));

  assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= MODE_HC0);

endmodule

// File: rtl/rdo_route.sv
module rdo_route
  import rdo_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdo_mode_e         mode_i,
  input  logic [WORD_W-1:0] hdac_i,
  input  logic [WORD_W-1:0] vdac_i,
  input  logic [WORD_W-1:0] cur0_i,
  input  logic [WORD_W-1:0] dref1_i,
  output logic [WORD_W-1:0] h_o,
  output logic [WORD_W-1:0] v_o
);

  logic [WORD_W-1:0] h_d, v_d;
  logic [WORD_W-1:0] h_q, v_q;
  logic              upd_en;

  always_comb begin
    upd_en = 1'b1;
    case (mode_i)
      MODE_VC1: begin h_d = hdac_i;  v_d = dref1_i; end
      MODE_HC1: begin h_d = dref1_i; v_d = hdac_i;  end
      MODE_VC0: begin h_d = hdac_i;  v_d = cur0_i;  end
      MODE_HC0: begin h_d = cur0_i;  v_d = hdac_i;  end
      default:  begin h_d = hdac_i;  v_d = vdac_i;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else if (upd_en) begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  assert_char_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_CHAR) |=> (h_o == $past(hdac_i) && v_o == $past(vdac_i)));

  assert_hcursor_vert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HC1 || mode_i == MODE_HC0) |=> (v_o == $past(hdac_i)));

  assert_vcursor_horz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_VC1 || mode_i == MODE_VC0) |=> (h_o == $past(hdac_i)));

endmodule

// File: rtl/readout_mode_sel.sv
module readout_mode_sel
  import rdo_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cur_sel,
  input  logic [2:0]        dot_data,
  input  logic              dot_req,
  input  logic [WORD_W-1:0] hdac_word,
  input  logic [WORD_W-1:0] vdac_word,
  input  logic [WORD_W-1:0] cur0_word,
  input  logic [WORD_W-1:0] dref1_word,
  output logic [WORD_W-1:0] h_defl,
  output logic [WORD_W-1:0] v_defl,
  output logic [2:0]        mode_code
);

  logic      rst_n;
  logic      rise;
  rdo_mode_e mode;

  rdo_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n)
  );

  rdo_strobe_det u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (dot_req),
    .rise_o   (rise)
  );

  rdo_mode_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .csel_i (cur_sel),
    .dd_i   (dot_data),
    .mode_o (mode)
  );

  rdo_route #(.WORD_W(WORD_W)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .hdac_i  (hdac_word),
    .vdac_i  (vdac_word),
    .cur0_i  (cur0_word),
    .dref1_i (dref1_word),
    .h_o     (h_defl),
    .v_o     (v_defl)
  );

  assign mode_code = mode;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (mode_code == 3'd0));

endmodule

// File: tb/readout_mode_sel_bench.sv
module readout_mode_sel_bench;

  localparam int W      = 10;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         arst_n;
  logic         cur_sel;
  logic [2:0]   dot_data;
  logic         dot_req;
  logic [W-1:0] hdac, vdac, cur0, dref1;
  logic [W-1:0] h_defl, v_defl;
  logic [2:0]   mode_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // model state
  bit       m_en, m_ret;
  int       m_mode;

  always #(CLK_NS/2) clk = ~clk;

  readout_mode_sel #(.WORD_W(W)) u_readout_mode_sel (
    .clk(clk), .arst_n(arst_n), .cur_sel(cur_sel), .dot_data(dot_data),
    .dot_req(dot_req), .hdac_word(hdac), .vdac_word(vdac), .cur0_word(cur0),
    .dref1_word(dref1), .h_defl(h_defl), .v_defl(v_defl), .mode_code(mode_code)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_h(input int m);
    case (m)
      2: return int'(dref1);
      4: return int'(cur0);
      default: return int'(hdac);
    endcase
  endfunction

  function automatic int exp_v(input int m);
    case (m)
      0: return int'(vdac);
      1: return int'(dref1);
      3: return int'(cur0);
      default: return int'(hdac);
    endcase
  endfunction

  // reference update for one strobe
  task automatic model_strobe(input bit cs, input bit [2:0] dd);
    bit en_in;
    en_in = (m_en && !m_ret) ? 1'b1 : cs;
    m_en  = en_in;
    if (!en_in) begin
      m_mode = 0; m_ret = 0;
    end else if (!dd[2] && !dd[1]) begin
      m_mode = 0; m_ret = 1;
    end else if (dd[2] && dd[1]) begin
      m_ret = 0;
    end else begin
      m_ret = 0;
      m_mode = (dd == 3'b010) ? 1 : (dd == 3'b011) ? 2 : (dd == 3'b100) ? 3 : 4;
    end
  endtask

  task automatic rand_sources();
    hdac = W'($urandom); vdac = W'($urandom);
    cur0 = W'($urandom); dref1 = W'($urandom);
  endtask

  // strobe held high for 'hold' clocks; data scrambled after the capturing edge
  task automatic strobe(input bit cs, input bit [2:0] dd, input int hold,
                        input string req);
    @(negedge clk);
    cur_sel = cs; dot_data = dd; dot_req = 1'b1;
    model_strobe(cs, dd);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      cur_sel = ~cs; dot_data = 3'($urandom);
    end
    dot_req = 1'b0;
    @(negedge clk);
    check(req, int'(mode_code), m_mode);
    check(req, int'(h_defl), exp_h(m_mode));
    check(req, int'(v_defl), exp_v(m_mode));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    arst_n = 1'b0; cur_sel = 1'b0; dot_data = 3'b000; dot_req = 1'b0;
    hdac = 10'h111; vdac = 10'h222; cur0 = 10'h333; dref1 = 10'h044;
    m_en = 0; m_ret = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    check("R1 reset mode", int'(mode_code), 0);
    check("R1 reset h", int'(h_defl), 0);
    check("R1 reset v", int'(v_defl), 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R3: enable clear after reset, low select gives character mode
    strobe(1'b0, 3'b010, 1, "R1 R3 char after reset");
    // R4/R5: entry decodes same strobe
    strobe(1'b1, 3'b010, 1, "R4 R5 vc1 entry");
    // R6: select low ignored
    strobe(1'b0, 3'b100, 1, "R6 R5 vc0 sticky");
    strobe(1'b0, 3'b011, 1, "R6 R9 hc1");
    strobe(1'b0, 3'b101, 1, "R6 R9 hc0");
    // R8: undefined pattern holds
    strobe(1'b0, 3'b111, 1, "R8 hold hc0");
    strobe(1'b1, 3'b110, 1, "R8 hold again");
    // R7: return, then select high continues
    strobe(1'b1, 3'b001, 1, "R7 return code");
    strobe(1'b1, 3'b100, 1, "R7 continue vc0");
    // R7: return, then select low exits
    strobe(1'b0, 3'b000, 1, "R7 return code 2");
    strobe(1'b0, 3'b011, 1, "R7 exit to char");
    // enable cleared: low select stays character
    strobe(1'b0, 3'b101, 1, "R3 stays char");
    // R2: long hold with data scrambling
    strobe(1'b1, 3'b011, 4, "R2 long hold hc1");
    check("R2 mode after hold", int'(mode_code), 2);

    // R10: source change appears one clock later
    @(negedge clk);
    hdac = 10'h2a5; dref1 = 10'h15a;
    check("R10 before edge", int'(v_defl) == 10'h2a5 ? 1 : 0, 0);
    @(negedge clk);
    check("R10 v one clock later", int'(v_defl), 10'h2a5);
    check("R10 h one clock later", int'(h_defl), 10'h15a);

    // R10: new mode reaches outputs one clock after mode_code
    strobe(1'b1, 3'b000, 1, "R7 return 3");
    @(negedge clk);
    cur_sel = 1'b1; dot_data = 3'b100; dot_req = 1'b1;
    model_strobe(1'b1, 3'b100);
    @(negedge clk);
    dot_req = 1'b0;
    check("R10 mode updated", int'(mode_code), 3);
    check("R10 v still old", int'(v_defl), int'(vdac));
    @(negedge clk);
    check("R10 v new", int'(v_defl), int'(cur0));

    // random phase
    for (int k = 0; k < 400; k++) begin
      bit [2:0] dd;
      bit cs;
      rand_sources();
      dd = 3'($urandom);
      cs = 1'($urandom);
      strobe(cs, dd, 1 + int'($urandom % 3), "R5 R6 R7 R8 R9 random");
      repeat ($urandom % 3) @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule